// File: doc/BRIEF.md
# Single-Cycle Integer Processor Core (Reduced RV32 Subset)

This block is a 32-bit processor core that retires exactly one instruction on every clock edge. Instruction fetch and data access use two separate ports, so an instruction and its data transfer happen in the same cycle. The core holds the program counter, the instruction decoder, a 32-entry register file, the arithmetic unit and the branch comparator. Memories and any address decoding for peripherals sit outside the core.

The supported instructions are a reduced integer subset:
- Register arithmetic: add, subtract, and, or, shift left, and arithmetic shift right.
- Immediate arithmetic: add, and, or, xor, and logical shift right.
- Loads: word, signed byte and unsigned byte. The only store is a word store.
- All six conditional branches, the jump-and-link, and load-upper-immediate.

Any other encoding retires as a no-op.

Both memory ports are plain combinational request/response pins rather than valid/ready channels. The core presents an address, the attached memory answers within the same cycle, and there is no back-pressure. A stall would break the one-instruction-per-cycle contract, so the attached memories must always answer in the same cycle.

Top module: `rvs_core`

## Requirements
- R1: A synchronous, active-high reset does four things. It sets the program counter to RESET_PC (default 0) and register x2 to SP_INIT (default 0x7fffeffc). It clears all other registers to 0. It holds `dmem_we` low while reset is asserted.
- R2: Register x0 always reads as 0. A result written to x0 is discarded.
- R3: Register-register instructions use opcode 0110011. With funct7 0000000 they are ADD (funct3 000), SLL (001), OR (110) and AND (111). With funct7 0100000 they are SUB (000) and SRA (101). Shifts use the low 5 bits of rs2, and the arithmetic shift replicates bit 31.
- R4: Register-immediate instructions use opcode 0010011. ADDI (funct3 000), XORI (100), ORI (110) and ANDI (111) use the sign-extended bits 31:20 as the immediate. SRLI is funct3 101 with bits 31:25 equal to 0, and its shift amount is bits 24:20.
- R5: LW (opcode 0000011, funct3 010) drives `dmem_addr` to rs1 plus the sign-extended bits 31:20, with `dmem_byte`=0. It writes the whole `dmem_rdata` word to rd.
- R6: LB (funct3 000) and LBU (funct3 100) drive `dmem_byte`=1. They pick byte lane `dmem_addr[1:0]` of `dmem_rdata`, where lane 0 is bits 7:0. LB sign-extends that byte into rd and LBU zero-extends it.
- R7: SW (opcode 0100011, funct3 010) raises `dmem_we` for its one cycle. It drives `dmem_addr` to rs1 plus the S-type immediate ({bits 31:25, bits 11:7}, sign-extended) and `dmem_wdata` to rs2. No other instruction raises `dmem_we`.
- R8: Branches use opcode 1100011: BEQ 000, BNE 001, BLT 100, BGE 101, BLTU 110, BGEU 111. BLT and BGE compare signed, and BLTU and BGEU compare unsigned. A taken branch moves the PC to PC plus the B-type immediate; an untaken branch moves it to PC+4.
- R9: JAL (opcode 1101111) writes PC+4 to rd and moves the PC to PC plus the J-type immediate.
- R10: LUI (opcode 0110111) writes {bits 31:12, 12 zero bits} to rd.
- R11: Every other encoding neither writes a register nor raises `dmem_we`, and the PC advances by 4. This covers unknown opcodes, jump-register, SLT/XOR/SRL register forms, SLLI, SRAI, halfword loads, byte stores, and branch funct3 010/011.
- R12: `imem_addr` always equals the current PC. Every instruction that is not a taken branch or a JAL advances the PC by 4 in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Byte address of the instruction being executed (the PC) |
| imem_data | input | 32 | Instruction word at `imem_addr`, valid in the same cycle |
| dmem_addr | output | 32 | Byte address for the current load or store |
| dmem_wdata | output | 32 | Word to store |
| dmem_we | output | 1 | Store strobe for the current cycle |
| dmem_byte | output | 1 | 1 for byte loads, 0 for word accesses |
| dmem_rdata | input | 32 | Word at the aligned `dmem_addr`, valid in the same cycle |

## Verification
The bench builds the core with its default parameters: RESET_PC = 0 and SP_INIT = 0x7fffeffc. The first fetch therefore comes from address 0. A store of x2 as the very first instruction exposes the stack reset value on `dmem_wdata`. Loads and stores are based on x0 with 12-bit offsets, so they all fall inside a 64 KB data model. Branches and jumps jump forward inside a 512-word program that loops back on itself. This lets thousands of cycles exercise every branch kind, byte lanes and sign bits, and the no-op encodings, with results observed at the ports.

// File: rtl/rvs_pkg.sv
package rvs_pkg;
  localparam int XLEN    = 32;
  localparam int REG_CNT = 32;
  localparam int REG_AW  = $clog2(REG_CNT);
  localparam int SHW     = $clog2(XLEN);

  localparam logic [6:0] OP_REG    = 7'b0110011;
  localparam logic [6:0] OP_IMM    = 7'b0010011;
  localparam logic [6:0] OP_LOAD   = 7'b0000011;
  localparam logic [6:0] OP_STORE  = 7'b0100011;
  localparam logic [6:0] OP_BRANCH = 7'b1100011;
  localparam logic [6:0] OP_JAL    = 7'b1101111;
  localparam logic [6:0] OP_LUI    = 7'b0110111;

  localparam logic [6:0] F7_BASE = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLL, ALU_SRL, ALU_SRA
  } alu_op_e;

  typedef enum logic [1:0] {WB_ALU, WB_LOAD, WB_LINK, WB_UPPER} wb_sel_e;

  typedef struct packed {
    logic              rf_we;
    logic              mem_we;
    logic              mem_byte;
    logic              load_signed;
    logic              is_branch;
    logic              is_jal;
    logic              use_imm;
    alu_op_e           alu_op;
    wb_sel_e           wb_sel;
    logic [2:0]        cmp_kind;
    logic [XLEN-1:0]   imm;
    logic [REG_AW-1:0] rd;
    logic [REG_AW-1:0] rs1;
    logic [REG_AW-1:0] rs2;
  } ctrl_t;
endpackage

// File: rtl/rvs_decode.sv
module rvs_decode
  import rvs_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output ctrl_t           ctl
);
  logic [6:0] op, f7;
  logic [2:0] f3;
  logic [XLEN-1:0] imm_i, imm_s, imm_b, imm_j, imm_u;

  assign op = instr[6:0];
  assign f3 = instr[14:12];
  assign f7 = instr[31:25];

  assign imm_i = {{(XLEN-12){instr[31]}}, instr[31:20]};
  assign imm_s = {{(XLEN-12){instr[31]}}, instr[31:25], instr[11:7]};
  assign imm_b = {{(XLEN-13){instr[31]}}, instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
  assign imm_j = {{(XLEN-21){instr[31]}}, instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};
  assign imm_u = {instr[31:12], 12'b0};

  always_comb begin
    ctl          = '0;
    ctl.rd       = instr[11:7];
    ctl.rs1      = instr[19:15];
    ctl.rs2      = instr[24:20];
    ctl.cmp_kind = f3;
    ctl.alu_op   = ALU_ADD;
    ctl.wb_sel   = WB_ALU;
    case (op)
      OP_REG: begin
        ctl.rf_we = 1'b1;
        if (f7 == F7_BASE && f3 == 3'b000)      ctl.alu_op = ALU_ADD;
        else if (f7 == F7_ALT && f3 == 3'b000)  ctl.alu_op = ALU_SUB;
        else if (f7 == F7_BASE && f3 == 3'b111) ctl.alu_op = ALU_AND;
        else if (f7 == F7_BASE && f3 == 3'b110) ctl.alu_op = ALU_OR;
        else if (f7 == F7_BASE && f3 == 3'b001) ctl.alu_op = ALU_SLL;
        else if (f7 == F7_ALT && f3 == 3'b101)  ctl.alu_op = ALU_SRA;
        else                                    ctl.rf_we  = 1'b0;
      end
      OP_IMM: begin
        ctl.rf_we   = 1'b1;
        ctl.use_imm = 1'b1;
        ctl.imm     = imm_i;
        case (f3)
          3'b000:  ctl.alu_op = ALU_ADD;
          3'b111:  ctl.alu_op = ALU_AND;
          3'b110:  ctl.alu_op = ALU_OR;
          3'b100:  ctl.alu_op = ALU_XOR;
          3'b101: begin
            ctl.alu_op = ALU_SRL;
            if (f7 != F7_BASE) ctl.rf_we = 1'b0;
          end
          default: ctl.rf_we = 1'b0;
        endcase
      end
      OP_LOAD: begin
        ctl.use_imm = 1'b1;
        ctl.imm     = imm_i;
        ctl.wb_sel  = WB_LOAD;
        case (f3)
          3'b010:  ctl.rf_we = 1'b1;
          3'b000: begin
            ctl.rf_we       = 1'b1;
            ctl.mem_byte    = 1'b1;
            ctl.load_signed = 1'b1;
          end
          3'b100: begin
            ctl.rf_we    = 1'b1;
            ctl.mem_byte = 1'b1;
          end
          default: ;
        endcase
      end
      OP_STORE: begin
        ctl.use_imm = 1'b1;
        ctl.imm     = imm_s;
        ctl.mem_we  = (f3 == 3'b010);
      end
      OP_BRANCH: begin
        ctl.imm       = imm_b;
        ctl.is_branch = (f3 != 3'b010) && (f3 != 3'b011);
      end
      OP_JAL: begin
        ctl.imm    = imm_j;
        ctl.is_jal = 1'b1;
        ctl.rf_we  = 1'b1;
        ctl.wb_sel = WB_LINK;
      end
      OP_LUI: begin
        ctl.imm    = imm_u;
        ctl.rf_we  = 1'b1;
        ctl.wb_sel = WB_UPPER;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rvs_regfile.sv
module rvs_regfile
  import rvs_pkg::*;
#(
  parameter int              SP_IDX  = 2,
  parameter logic [XLEN-1:0] SP_INIT = 32'h7fffeffc
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] ra_a,
  input  logic [REG_AW-1:0] ra_b,
  output logic [XLEN-1:0]   rd_a,
  output logic [XLEN-1:0]   rd_b,
  input  logic              we,
  input  logic [REG_AW-1:0] wa,
  input  logic [XLEN-1:0]   wd
);
  logic [XLEN-1:0] regs [REG_CNT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < REG_CNT; k++)
        regs[k] <= (k == SP_IDX) ? SP_INIT : '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];

  // R2: register zero never returns a non-zero value
  a_r2_zero_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (ra_a == '0) |-> (rd_a == '0));

  // R1: stack register carries its reset value right after reset
  a_r1_sp_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (regs[SP_IDX] == SP_INIT));
endmodule

// File: rtl/rvs_alu.sv
module rvs_alu
  import rvs_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y
);
  logic [SHW-1:0] sh;
  assign sh = b[SHW-1:0];

  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      ALU_SLL: y = a << sh;
      ALU_SRL: y = a >> sh;
      ALU_SRA: y = $unsigned($signed(a) >>> sh);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/rvs_branch.sv
module rvs_branch
  import rvs_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [2:0]      kind,
  output logic            take
);
  logic eq, lt_s, lt_u;
  assign eq   = (a == b);
  assign lt_s = ($signed(a) < $signed(b));
  assign lt_u = (a < b);

  always_comb begin
    case (kind)
      3'b000:  take = eq;
      3'b001:  take = !eq;
      3'b100:  take = lt_s;
      3'b101:  take = !lt_s;
      3'b110:  take = lt_u;
      3'b111:  take = !lt_u;
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/rvs_core.sv
module rvs_core
  import rvs_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0,
  parameter logic [XLEN-1:0] SP_INIT  = 32'h7fffeffc
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [XLEN-1:0] imem_data,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  output logic            dmem_byte,
  input  logic [XLEN-1:0] dmem_rdata
);
  ctrl_t           ctl;
  logic [XLEN-1:0] pc_q, pc_next, pc_inc, pc_tgt;
  logic [XLEN-1:0] rs1_v, rs2_v, opnd_b, alu_y, load_v, wb_v, lane_v;
  logic            take;
  logic [7:0]      lane_byte;

  rvs_decode u_dec (.instr(imem_data), .ctl(ctl));

  rvs_regfile #(.SP_IDX(2), .SP_INIT(SP_INIT)) u_rf (
    .clk(clk), .rst(rst),
    .ra_a(ctl.rs1), .ra_b(ctl.rs2), .rd_a(rs1_v), .rd_b(rs2_v),
    .we(ctl.rf_we), .wa(ctl.rd), .wd(wb_v)
  );

  assign opnd_b = ctl.use_imm ? ctl.imm : rs2_v;

  rvs_alu u_alu (.a(rs1_v), .b(opnd_b), .op(ctl.alu_op), .y(alu_y));

  rvs_branch u_br (.a(rs1_v), .b(rs2_v), .kind(ctl.cmp_kind), .take(take));

  assign lane_v    = dmem_rdata >> {alu_y[1:0], 3'b000};
  assign lane_byte = lane_v[7:0];
  assign load_v    = !ctl.mem_byte ? dmem_rdata
                   : {{(XLEN-8){ctl.load_signed & lane_byte[7]}}, lane_byte};

  assign pc_inc = pc_q + XLEN'(4);
  assign pc_tgt = pc_q + ctl.imm;

  always_comb begin
    case (ctl.wb_sel)
      WB_LOAD:  wb_v = load_v;
      WB_LINK:  wb_v = pc_inc;
      WB_UPPER: wb_v = ctl.imm;
      default:  wb_v = alu_y;
    endcase
  end

  assign pc_next = (ctl.is_jal || (ctl.is_branch && take)) ? pc_tgt : pc_inc;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= pc_next;
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rs2_v;
  assign dmem_we    = ctl.mem_we & !rst;
  assign dmem_byte  = ctl.mem_byte;

  // R1: first fetch after reset comes from the reset address
  a_r1_pc_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (imem_addr == RESET_PC));

  // R7: the store strobe only rises for a word-store encoding
  a_r7_store_only: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> (imem_data[6:0] == OP_STORE && imem_data[14:12] == 3'b010));

  // R6: byte size is only signalled for loads
  a_r6_byte_on_load: assert property (@(posedge clk) disable iff (rst)
    dmem_byte |-> (imem_data[6:0] == OP_LOAD));

  // R12: non-control-flow instructions step the PC by 4
  a_r12_sequential: assert property (@(posedge clk) disable iff (rst)
    (imem_data[6:0] != OP_BRANCH && imem_data[6:0] != OP_JAL)
      |=> (imem_addr == $past(imem_addr) + XLEN'(4)));

  // R11: unknown opcodes neither write a register nor store
  a_r11_unknown_quiet: assert property (@(posedge clk) disable iff (rst)
    (imem_data[6:0] != OP_REG && imem_data[6:0] != OP_IMM &&
     imem_data[6:0] != OP_LOAD && imem_data[6:0] != OP_STORE &&
     imem_data[6:0] != OP_BRANCH && imem_data[6:0] != OP_JAL &&
     imem_data[6:0] != OP_LUI) |-> (!ctl.rf_we && !dmem_we));
endmodule

// File: tb/rvs_core_test.sv
module rvs_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int PWORDS     = 512;
  localparam int PAW        = 9;
  localparam int DWORDS     = 16384;
  localparam int NCYC       = 4000;
  localparam int LOOP_AT    = 11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, dmem_byte;

  logic [31:0] imem [PWORDS];
  logic [31:0] dmem [DWORDS];
  logic [31:0] mmem [DWORDS];
  logic [31:0] mregs [32];
  string       src_tag [32];
  logic [31:0] mpc;
  string       pc_tag;
  int          n_run = 0;
  int          n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rvs_core uut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_byte(dmem_byte), .dmem_rdata(dmem_rdata)
  );

  assign imem_data  = imem[imem_addr[PAW+1:2]];
  assign dmem_rdata = dmem[dmem_addr[15:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[15:2]] <= dmem_wdata;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] r2, r1,
                                        input logic [2:0] f3, input logic [4:0] rd);
    return {f7, r2, r1, f3, rd, 7'b0110011};
  endfunction
  function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] r1,
                                        input logic [2:0] f3, input logic [4:0] rd,
                                        input logic [6:0] op);
    return {imm, r1, f3, rd, op};
  endfunction
  function automatic logic [31:0] enc_s(input logic [11:0] imm, input logic [4:0] r2, r1,
                                        input logic [2:0] f3);
    return {imm[11:5], r2, r1, f3, imm[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] enc_b(input logic [12:0] imm, input logic [4:0] r2, r1,
                                        input logic [2:0] f3);
    return {imm[12], imm[10:5], r2, r1, f3, imm[4:1], imm[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] enc_j(input logic [20:0] imm, input logic [4:0] rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, 7'b1101111};
  endfunction

  function automatic int fwd_off(input int idx);
    int o = 1 + int'($urandom % 8);
    if (idx + o > PWORDS - 1) o = 1;
    return o * 4;
  endfunction

  function automatic logic [31:0] rand_instr(input int idx);
    logic [4:0] rd = 5'($urandom), r1 = 5'($urandom), r2 = 5'($urandom);
    logic [2:0] bk [6] = '{3'b000, 3'b001, 3'b100, 3'b101, 3'b110, 3'b111};
    int k = int'($urandom % 16);
    if (($urandom % 4) == 0) r2 = r1;
    case (k)
      0, 1, 2: case ($urandom % 6)
        0: return enc_r(7'h00, r2, r1, 3'b000, rd);
        1: return enc_r(7'h20, r2, r1, 3'b000, rd);
        2: return enc_r(7'h00, r2, r1, 3'b111, rd);
        3: return enc_r(7'h00, r2, r1, 3'b110, rd);
        4: return enc_r(7'h00, r2, r1, 3'b001, rd);
        default: return enc_r(7'h20, r2, r1, 3'b101, rd);
      endcase
      3, 4, 5: case ($urandom % 5)
        0: return enc_i(12'($urandom), r1, 3'b000, rd, 7'b0010011);
        1: return enc_i(12'($urandom), r1, 3'b111, rd, 7'b0010011);
        2: return enc_i(12'($urandom), r1, 3'b110, rd, 7'b0010011);
        3: return enc_i(12'($urandom), r1, 3'b100, rd, 7'b0010011);
        default: return enc_i({7'b0, 5'($urandom)}, r1, 3'b101, rd, 7'b0010011);
      endcase
      6: return {20'($urandom), rd, 7'b0110111};
      7: return enc_i({12'($urandom % 512) << 2}, 5'd0, 3'b010, rd, 7'b0000011);
      8: return enc_i(12'($urandom % 2048), 5'd0, ($urandom % 2) ? 3'b100 : 3'b000,
                     rd, 7'b0000011);
      11: return enc_b(13'(fwd_off(idx)), r2, r1, bk[$urandom % 6]);
      12: return enc_j(21'(fwd_off(idx)), rd);
      13: case ($urandom % 10)
        0: return {25'($urandom), 7'b1110011};
        1: return {25'($urandom), 7'b0001111};
        2: return enc_i(12'd0, r1, 3'b000, rd, 7'b1100111);
        3: return enc_r(7'h00, r2, r1, 3'b100, rd);
        4: return enc_r(7'h00, r2, r1, 3'b101, rd);
        5: return enc_i({7'h20, 5'($urandom)}, r1, 3'b101, rd, 7'b0010011);
        6: return enc_i({7'h00, 5'($urandom)}, r1, 3'b001, rd, 7'b0010011);
        7: return enc_i(12'd64, 5'd0, 3'b001, rd, 7'b0000011);
        8: return enc_s(12'd64, r2, 5'd0, 3'b000);
        default: return enc_b(13'd8, r2, r1, 3'b010);
      endcase
      default: return enc_s({12'($urandom % 512) << 2}, r2, 5'd0, 3'b010);
    endcase
  endfunction

  task automatic step_model();
    logic [31:0] ins, a, b, ii, is, ib, ij, res, addr, word, nxt;
    logic [7:0]  byt;
    logic [6:0]  op, f7;
    logic [2:0]  f3;
    logic [4:0]  rd, r1, r2;
    logic        wr, st, ld, bsz, tk;
    string       cls, nxt_tag;
    ins = imem[mpc[PAW+1:2]];
    op = ins[6:0]; f3 = ins[14:12]; f7 = ins[31:25];
    rd = ins[11:7]; r1 = ins[19:15]; r2 = ins[24:20];
    a = mregs[r1]; b = mregs[r2];
    ii = {{20{ins[31]}}, ins[31:20]};
    is = {{20{ins[31]}}, ins[31:25], ins[11:7]};
    ib = {{19{ins[31]}}, ins[31], ins[7], ins[30:25], ins[11:8], 1'b0};
    ij = {{11{ins[31]}}, ins[31], ins[19:12], ins[20], ins[30:21], 1'b0};
    nxt = mpc + 4; wr = 0; st = 0; ld = 0; bsz = 0; res = 0; addr = 0;
    cls = "R11"; nxt_tag = "R12";
    case (op)
      7'b0110011: begin
        cls = "R3"; wr = 1;
        if (f7 == 7'h00 && f3 == 3'b000) res = a + b;
        else if (f7 == 7'h20 && f3 == 3'b000) res = a - b;
        else if (f7 == 7'h00 && f3 == 3'b111) res = a & b;
        else if (f7 == 7'h00 && f3 == 3'b110) res = a | b;
        else if (f7 == 7'h00 && f3 == 3'b001) res = a << b[4:0];
        else if (f7 == 7'h20 && f3 == 3'b101) res = $unsigned($signed(a) >>> b[4:0]);
        else begin wr = 0; cls = "R11"; end
      end
      7'b0010011: begin
        cls = "R4"; wr = 1;
        if (f3 == 3'b000) res = a + ii;
        else if (f3 == 3'b111) res = a & ii;
        else if (f3 == 3'b110) res = a | ii;
        else if (f3 == 3'b100) res = a ^ ii;
        else if (f3 == 3'b101 && f7 == 7'h00) res = a >> ins[24:20];
        else begin wr = 0; cls = "R11"; end
      end
      7'b0000011: begin
        addr = a + ii; word = mmem[addr[15:2]];
        byt = 8'(word >> (8 * addr[1:0]));
        if (f3 == 3'b010) begin cls = "R5"; wr = 1; ld = 1; res = word; end
        else if (f3 == 3'b000) begin cls = "R6"; wr = 1; ld = 1; bsz = 1; res = {{24{byt[7]}}, byt}; end
        else if (f3 == 3'b100) begin cls = "R6"; wr = 1; ld = 1; bsz = 1; res = {24'b0, byt}; end
      end
      7'b0100011: if (f3 == 3'b010) begin cls = "R7"; st = 1; addr = a + is; end
      7'b1100011: begin
        tk = 0;
        case (f3)
          3'b000: tk = (a == b);
          3'b001: tk = (a != b);
          3'b100: tk = ($signed(a) < $signed(b));
          3'b101: tk = ($signed(a) >= $signed(b));
          3'b110: tk = (a < b);
          3'b111: tk = (a >= b);
          default: tk = 0;
        endcase
        if (f3 != 3'b010 && f3 != 3'b011) begin
          cls = "R8"; nxt_tag = "R8";
          if (tk) nxt = mpc + ib;
        end
      end
      7'b1101111: begin cls = "R9"; nxt_tag = "R9"; wr = 1; res = mpc + 4; nxt = mpc + ij; end
      7'b0110111: begin cls = "R10"; wr = 1; res = {ins[31:12], 12'b0}; end
      default: ;
    endcase
    chk(dmem_we === st, cls, "dmem_we", {31'b0, dmem_we}, {31'b0, st});
    if (st) begin
      chk(dmem_addr === addr, "R7", "store address", dmem_addr, addr);
      chk(dmem_wdata === b, src_tag[r2], "stored register value", dmem_wdata, b);
      mmem[addr[15:2]] = b;
    end
    if (ld) begin
      chk(dmem_addr === addr, cls, "load address", dmem_addr, addr);
      chk(dmem_byte === bsz, cls, "load size", {31'b0, dmem_byte}, {31'b0, bsz});
    end
    if (wr && rd != 0) begin
      mregs[rd] = res;
      src_tag[rd] = cls;
    end
    mpc = nxt;
    pc_tag = nxt_tag;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < DWORDS; i++) begin
      dmem[i] = $urandom;
      mmem[i] = dmem[i];
    end
    imem[0]  = enc_s(12'd0, 5'd2, 5'd0, 3'b010);           // R1 stack value out
    imem[1]  = enc_s(12'd4, 5'd5, 5'd0, 3'b010);           // R1 cleared register
    imem[2]  = enc_i(12'd123, 5'd0, 3'b000, 5'd0, 7'b0010011); // R2 write to x0
    imem[3]  = enc_s(12'd8, 5'd0, 5'd0, 3'b010);           // R2 x0 still zero
    imem[4]  = {20'h80000, 5'd7, 7'b0110111};              // R10 lui
    imem[5]  = enc_i(12'd31, 5'd0, 3'b000, 5'd9, 7'b0010011);
    imem[6]  = enc_r(7'h20, 5'd9, 5'd7, 3'b101, 5'd8);     // R3 sra sign fill
    imem[7]  = enc_s(12'd12, 5'd8, 5'd0, 3'b010);
    imem[8]  = enc_b(13'd8, 5'd0, 5'd7, 3'b100);           // R8 blt taken
    imem[9]  = enc_i(12'd1, 5'd0, 3'b000, 5'd10, 7'b0010011);
    imem[10] = enc_b(13'd8, 5'd0, 5'd7, 3'b110);           // R8 bltu not taken
    for (int i = LOOP_AT; i < PWORDS - 1; i++) imem[i] = rand_instr(i);
    imem[PWORDS-1] = enc_j(21'((LOOP_AT - (PWORDS - 1)) * 4), 5'd0);

    for (int i = 0; i < 32; i++) begin
      mregs[i] = (i == 2) ? 32'h7fffeffc : 32'h0;
      src_tag[i] = (i == 0) ? "R2" : "R1";
    end
    mpc = 0;
    pc_tag = "R1";

    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dmem_we === 1'b0, "R1", "store strobe in reset", {31'b0, dmem_we}, 32'h0);
    chk(imem_addr === 32'h0, "R1", "pc in reset", imem_addr, 32'h0);
    rst = 1'b0;
    #1;
    for (int c = 0; c < NCYC; c++) begin
      chk(imem_addr === mpc, pc_tag, "pc", imem_addr, mpc);
      step_model();
      @(negedge clk);
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule